// File: doc/BRIEF.md
# Match-to-Port Forwarding Stage

This block sits after a ternary match array in a packet classifier. Each cycle it may take one packet: a vector with one match line per stored rule, and the packet data word. It then decides which output node gets that packet. First, a priority stage reduces the match lines to the index of the winning rule. That index then reads a pointer table, which holds one binary node code per rule. Last, a one-of-N steering stage raises the valid of exactly one output channel and places the packet word on it.

The three steps are split by pipeline registers. The stage accepts a new packet on every clock and delivers each result a fixed three cycles later. The pointer table can be rewritten at run time, so that rules can be reassigned to other nodes while traffic flows. A parameter instead turns the table into fixed contents. A packet that hits no rule activates no channel and raises a one-cycle miss flag.

Top module: `fwd_stage`

## Requirements
- R1: After reset, all channel valids, the miss flag and all channel data are zero, and the pointer table maps rule i to node code i mod N_NODES.
- R2: When several match lines are set, the rule with the lowest index selects the node.
- R3: The result of a packet presented on clock edge k appears after edge k+3, and one packet may be presented on every edge.
- R4: For a packet with at least one match, exactly one channel valid is high: channel c, where c is the binary node code stored for the winning rule (code 0 is channel 0).
- R5: For a valid packet with no match line set, no channel valid is raised and out_miss is high for exactly that packet's output cycle.
- R6: Channel c carries its data in out_data[c*DATA_W +: DATA_W]. The active channel carries the packet word from the same input cycle, and every inactive channel carries zero.
- R7: A write with tbl_we high stores tbl_code for rule tbl_addr. A packet presented in the same cycle as the write, or in any later cycle, uses the new code. A packet presented one cycle earlier uses the old code.
- R8: While in_vld is low, in_match and in_data are ignored: no channel valid and no miss results three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Packet present this cycle |
| in_match | input | N_RULES | Match lines, bit i for rule i |
| in_data | input | DATA_W | Packet data word |
| tbl_we | input | 1 | Pointer-table write enable |
| tbl_addr | input | IDX_W | Rule index to write |
| tbl_code | input | PTR_W | Node code to store |
| out_vld | output | N_NODES | One valid per output channel |
| out_data | output | N_NODES*DATA_W | Data of all channels, channel c at c*DATA_W |
| out_miss | output | 1 | Packet matched no rule |

## Verification
The hardest case to reach is a table write that lands on the exact boundary between two packets which use the same rule. On that boundary, the packet presented one cycle before the write must still leave on the old node, and the packet presented in the same cycle must already use the new one. Directed sequences present the same single-rule match across the write cycle to pin both sides of this boundary. Random traffic then mixes further writes with dense, overlapping match vectors, and a bench model of the table tracks the expected node for each packet.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // Reset and fixed-table contents: rules spread round-robin over nodes.
   function automatic int default_code(input int rule, input int nodes);
      return rule % nodes;
   endfunction
endpackage

// File: rtl/fwd_prio_enc.sv
module fwd_prio_enc #(
   parameter int N_RULES = 8,
   localparam int IDX_W = $clog2(N_RULES)
) (
   input  logic [N_RULES-1:0] match,
   output logic [IDX_W-1:0]   idx,
   output logic               hit
);
   always_comb begin
      idx = '0;
      hit = 1'b0;
      // Scan downwards so the lowest set line is written last and wins.
      for (int i = N_RULES - 1; i >= 0; i--) begin
         if (match[i]) begin
            idx = IDX_W'(i);
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fwd_ptr_table.sv
module fwd_ptr_table #(
   parameter int N_RULES     = 8,
   parameter int N_NODES     = 4,
   parameter bit FIXED_TABLE = 1'b0,
   localparam int IDX_W = $clog2(N_RULES),
   localparam int PTR_W = $clog2(N_NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [PTR_W-1:0] wcode,
   input  logic [IDX_W-1:0] raddr,
   output logic [PTR_W-1:0] rcode
);
   logic [PTR_W-1:0] entry [N_RULES];

   generate
      if (FIXED_TABLE) begin : g_fixed
         for (genvar r = 0; r < N_RULES; r++) begin : g_ent
            assign entry[r] = PTR_W'(fwd_pkg::default_code(r, N_NODES));
         end
      end else begin : g_ram
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int r = 0; r < N_RULES; r++)
                  entry[r] <= PTR_W'(fwd_pkg::default_code(r, N_NODES));
            end else if (we && (int'(waddr) < N_RULES)) begin
               entry[waddr] <= wcode;
            end
         end
      end
   endgenerate

   assign rcode = (int'(raddr) < N_RULES) ? entry[raddr] : '0;
endmodule

// File: rtl/fwd_demux.sv
module fwd_demux #(
   parameter int N_NODES = 4,
   parameter int DATA_W  = 32,
   localparam int PTR_W = $clog2(N_NODES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      vld,
   input  logic                      hit,
   input  logic [PTR_W-1:0]          code,
   input  logic [DATA_W-1:0]         data,
   output logic [N_NODES-1:0]        ch_vld,
   output logic [N_NODES*DATA_W-1:0] ch_data,
   output logic                      miss
);
   logic [N_NODES-1:0] sel;

   for (genvar c = 0; c < N_NODES; c++) begin : g_dec
      assign sel[c] = vld && hit && (code == PTR_W'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_vld  <= '0;
         ch_data <= '0;
         miss    <= 1'b0;
      end else begin
         ch_vld <= sel;
         miss   <= vld && !hit;
         for (int c = 0; c < N_NODES; c++)
            ch_data[c*DATA_W +: DATA_W] <= sel[c] ? data : '0;
      end
   end
endmodule

// File: rtl/fwd_stage.sv
module fwd_stage #(
   parameter int N_RULES     = 8,
   parameter int N_NODES     = 4,
   parameter int DATA_W      = 32,
   parameter bit FIXED_TABLE = 1'b0,
   localparam int IDX_W = $clog2(N_RULES),
   localparam int PTR_W = $clog2(N_NODES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [N_RULES-1:0]        in_match,
   input  logic [DATA_W-1:0]         in_data,
   input  logic                      tbl_we,
   input  logic [IDX_W-1:0]          tbl_addr,
   input  logic [PTR_W-1:0]          tbl_code,
   output logic [N_NODES-1:0]        out_vld,
   output logic [N_NODES*DATA_W-1:0] out_data,
   output logic                      out_miss
);
   if (N_RULES < 2) begin : g_bad_rules
      $error("fwd_stage: N_RULES must be at least 2");
   end
   if (N_NODES < 2) begin : g_bad_nodes
      $error("fwd_stage: N_NODES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("fwd_stage: DATA_W must be positive");
   end

   // Stage 1: priority resolution.
   logic [IDX_W-1:0]  enc_idx;
   logic              enc_hit;
   logic              s1_vld, s1_hit;
   logic [IDX_W-1:0]  s1_idx;
   logic [DATA_W-1:0] s1_data;

   fwd_prio_enc #(.N_RULES(N_RULES)) u_enc (
      .match(in_match), .idx(enc_idx), .hit(enc_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_hit  <= 1'b0;
         s1_idx  <= '0;
         s1_data <= '0;
      end else begin
         s1_vld  <= in_vld;
         s1_hit  <= in_vld && enc_hit;
         s1_idx  <= enc_idx;
         s1_data <= in_data;
      end
   end

   // Stage 2: pointer lookup.
   logic [PTR_W-1:0]  tbl_rd;
   logic              s2_vld, s2_hit;
   logic [PTR_W-1:0]  s2_code;
   logic [DATA_W-1:0] s2_data;

   fwd_ptr_table #(
      .N_RULES(N_RULES), .N_NODES(N_NODES), .FIXED_TABLE(FIXED_TABLE)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
      .wcode(tbl_code), .raddr(s1_idx), .rcode(tbl_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_hit  <= 1'b0;
         s2_code <= '0;
         s2_data <= '0;
      end else begin
         s2_vld  <= s1_vld;
         s2_hit  <= s1_hit;
         s2_code <= tbl_rd;
         s2_data <= s1_data;
      end
   end

   // Stage 3: channel steering.
   fwd_demux #(.N_NODES(N_NODES), .DATA_W(DATA_W)) u_dmx (
      .clk(clk), .rst_n(rst_n), .vld(s2_vld), .hit(s2_hit),
      .code(s2_code), .data(s2_data),
      .ch_vld(out_vld), .ch_data(out_data), .miss(out_miss)
   );
endmodule

// File: rtl/fwd_stage_chk.sv
module fwd_stage_chk #(
   parameter int N_RULES = 8,
   parameter int N_NODES = 4,
   parameter int DATA_W  = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_vld,
   input logic [N_RULES-1:0]        in_match,
   input logic [N_NODES-1:0]        out_vld,
   input logic [N_NODES*DATA_W-1:0] out_data,
   input logic                      out_miss
);
   // R4: never more than one channel active
   p_one_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_vld));

   // R5: a miss activates no channel
   p_miss_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> (out_vld == '0));

   // R5: a miss comes from a valid packet with no match lines, three cycles back
   p_miss_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> ($past(in_vld, 3) && ($past(in_match, 3) == '0)));

   // R3 / R8: any output activity traces to a valid packet three cycles back
   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_vld != '0) || out_miss) |-> $past(in_vld, 3));

   // R3: every valid packet produces a result three cycles later
   p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld, 3) |-> ((out_vld != '0) || out_miss));

   // R6: with no active channel the data bus stays zero
   p_idle_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld == '0) |-> (out_data == '0));
endmodule

bind fwd_stage fwd_stage_chk #(
   .N_RULES(N_RULES), .N_NODES(N_NODES), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_match(in_match),
   .out_vld(out_vld), .out_data(out_data), .out_miss(out_miss)
);

// File: tb/sim_fwd_stage.sv
`timescale 1ns/1ps
module sim_fwd_stage;
   localparam int NR = 8;
   localparam int NN = 4;
   localparam int DW = 32;
   localparam int IW = $clog2(NR);
   localparam int PW = $clog2(NN);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_vld = 1'b0;
   logic [NR-1:0]     in_match = '0;
   logic [DW-1:0]     in_data = '0;
   logic              tbl_we = 1'b0;
   logic [IW-1:0]     tbl_addr = '0;
   logic [PW-1:0]     tbl_code = '0;
   logic [NN-1:0]     out_vld;
   logic [NN*DW-1:0]  out_data;
   logic              out_miss;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fwd_stage #(.N_RULES(NR), .N_NODES(NN), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_match(in_match),
      .in_data(in_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_code(tbl_code), .out_vld(out_vld), .out_data(out_data),
      .out_miss(out_miss)
   );

   // Bench model state
   logic [PW-1:0]    model_tbl [NR];
   logic [NN-1:0]    exp_vld  [4];
   logic [NN*DW-1:0] exp_data [4];
   logic             exp_miss [4];
   string            exp_tag  [4];

   function automatic int lowest(input logic [NR-1:0] m);
      for (int i = 0; i < NR; i++) if (m[i]) return i;
      return -1;
   endfunction

   task automatic chk(input string tag, input logic [NN*DW-1:0] act,
                      input logic [NN*DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One cycle: check the packet from three cycles ago, then drive this one.
   task automatic step(input logic v, input logic [NR-1:0] m, input logic [DW-1:0] d,
                       input logic we, input int wa, input int wc, input string tag);
      int s;
      int w;
      @(negedge clk);
      if (cyc >= 3) begin
         s = (cyc - 3) % 4;
         chk({exp_tag[s], " R4 out_vld"}, NN*DW'(out_vld), NN*DW'(exp_vld[s]));
         chk({exp_tag[s], " R5 out_miss"}, NN*DW'(out_miss), NN*DW'(exp_miss[s]));
         chk({exp_tag[s], " R6 out_data"}, out_data, exp_data[s]);
      end
      in_vld = v; in_match = m; in_data = d;
      tbl_we = we; tbl_addr = IW'(wa); tbl_code = PW'(wc);
      if (we) model_tbl[wa] = PW'(wc);   // R7: same-cycle packet sees new code
      s = cyc % 4;
      w = lowest(m);
      exp_tag[s] = tag;
      exp_vld[s] = '0;
      exp_data[s] = '0;
      exp_miss[s] = v && (w < 0);
      if (v && w >= 0) begin
         exp_vld[s][model_tbl[w]] = 1'b1;
         exp_data[s][int'(model_tbl[w])*DW +: DW] = d;
      end
      cyc++;
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b0, 0, 0, "R8 idle");
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NR; i++) model_tbl[i] = PW'(i % NN);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values at the ports
      chk("R1 out_vld at reset", NN*DW'(out_vld), '0);
      chk("R1 out_miss at reset", NN*DW'(out_miss), '0);
      chk("R1 out_data at reset", out_data, '0);
      rst_n = 1'b1;

      // R1 / R3: read back the reset table, one rule per back-to-back packet
      for (int i = 0; i < NR; i++)
         step(1'b1, NR'(1) << i, 32'hA000_0000 + i, 1'b0, 0, 0, "R1 R3 reset table");
      // R2: several lines set, lowest wins
      step(1'b1, 8'b1111_1110, 32'h1111_0001, 1'b0, 0, 0, "R2 multi");
      step(1'b1, 8'b1000_0100, 32'h1111_0002, 1'b0, 0, 0, "R2 multi");
      step(1'b1, 8'b1111_1111, 32'h1111_0003, 1'b0, 0, 0, "R2 all");
      step(1'b1, 8'b1100_0000, 32'h1111_0004, 1'b0, 0, 0, "R2 high");
      // R5: misses, back to back and between hits
      step(1'b1, 8'h00, 32'h2222_0001, 1'b0, 0, 0, "R5 miss");
      step(1'b1, 8'h00, 32'h2222_0002, 1'b0, 0, 0, "R5 miss");
      step(1'b1, 8'h10, 32'h2222_0003, 1'b0, 0, 0, "R5 hit after miss");
      // R8: matches with in_vld low are ignored
      step(1'b0, 8'hFF, 32'hDEAD_BEEF, 1'b0, 0, 0, "R8 ignored");
      step(1'b0, 8'h01, 32'hDEAD_BEEF, 1'b0, 0, 0, "R8 ignored");
      flush();
      // R7: write boundary for rule 5 (reset code 1 -> new code 3)
      step(1'b1, 8'h20, 32'h3333_0001, 1'b0, 0, 0, "R7 before write");
      step(1'b1, 8'h20, 32'h3333_0002, 1'b1, 5, 3, "R7 same-cycle write");
      step(1'b1, 8'h20, 32'h3333_0003, 1'b0, 0, 0, "R7 after write");
      // R7: rewrite rule 0 to code 2 while rule 0 traffic flows
      step(1'b1, 8'h01, 32'h3333_0004, 1'b1, 0, 2, "R7 rewrite");
      step(1'b1, 8'h03, 32'h3333_0005, 1'b0, 0, 0, "R7 R2 rewritten");
      flush();

      // Random mix
      for (int n = 0; n < 800; n++) begin
         logic [NR-1:0] m;
         m = NR'($urandom) & NR'($urandom);
         if ($urandom_range(0, 7) == 0) m = '0;
         step($urandom_range(0, 5) != 0, m, $urandom,
              $urandom_range(0, 9) == 0, $urandom_range(0, NR-1),
              $urandom_range(0, NN-1), "R2 R3 R7 random");
      end
      flush();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule